// File: doc/BRIEF.md
# Remote Terminal Subsystem Transfer Handshake

This block sits between the protocol core of a serial-bus remote terminal and the host subsystem that owns the message buffers. When the core has decoded a command that needs the host's parallel bus, it pulses a start input. The block then drives an active-low request and waits a bounded number of cycles for an active-low grant. Once the grant is seen, the block walks through a fixed sequence of word slots. The first slot carries the latched command word. The slots after it carry the data words, which the core supplies according to the slot index the block reports. In the middle of every slot the block drives a short active-low strobe, so the host can capture the word on the strobe's rising edge. A second output tells the host whether the current slot holds the command word or a data word.

If no grant arrives before the timeout, the block gives up cleanly and sets a sticky handshake-failure flag. Only the next bus-start pulse clears that flag. An in-command output stays high for the whole time a command is being serviced. The slot length, strobe width and grant timeout are all counted in system clock cycles and set by parameters.

Top module: `rt_xfer_handshake`

## Requirements
- R1: After reset, req_n and strobe_n are high, in_cmd and dat_ncmd are low, and hs_fail_n is high.
- R2: A high xfer_start sampled while idle drives req_n low on the next cycle. A high xfer_start sampled at any other time has no effect on the sequence.
- R3: grant_n is sampled only while a request is pending. A low grant_n sampled while idle has no effect. Once the transfer has begun, grant_n may return high without effect. A grant sampled in the final waiting cycle starts the transfer, and the timeout does not fire.
- R4: A transfer presents 1 + N word slots, where N is word_cnt and a word_cnt of 0 means 32. In slot 0, bus_data is the cmd_word latched at start. In slot k (k >= 1), word_idx equals k and bus_data equals data_word.
- R5: dat_ncmd is low during the command slot and high during every data slot.
- R6: Each slot lasts SLOT_CYC cycles and carries exactly one strobe_n low pulse. The pulse is STB_CYC cycles wide and begins (SLOT_CYC-STB_CYC)/2 cycles after the slot starts. strobe_n never goes low outside a transfer.
- R7: After the last slot, req_n returns high and in_cmd falls in the same cycle.
- R8: If no grant is sampled for GNT_TMO cycles after the request, then in a single cycle req_n returns high, in_cmd falls and hs_fail_n goes low. No strobe is issued.
- R9: hs_fail_n stays low until a bus_start pulse is sampled, and goes high on the following cycle. A timeout in the same cycle as bus_start leaves it low.
- R10: in_cmd rises together with the fall of req_n and stays high until the transfer ends or times out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | One-cycle request from the terminal core to begin a transfer |
| word_cnt | input | WCW | Number of data words; 0 means 2**WCW |
| cmd_word | input | DW | Command word, latched at start |
| data_word | input | DW | Data word for the current slot, supplied by the core |
| bus_start | input | 1 | New bus-start pulse; clears the failure flag |
| grant_n | input | 1 | Active-low transfer grant from the host |
| req_n | output | 1 | Active-low transfer request to the host |
| in_cmd | output | 1 | High while a command is being serviced |
| strobe_n | output | 1 | Active-low mid-slot write strobe |
| dat_ncmd | output | 1 | Low for the command slot, high for data slots |
| word_idx | output | WCW+1 | Current slot index (0 = command word) |
| bus_data | output | DW | Word presented on the parallel bus |
| hs_fail_n | output | 1 | Sticky active-low handshake failure flag |

## Verification
Several rules are checked by assertions on every cycle. These cover the coupling of req_n and in_cmd at both ends of a transfer, and a strobe_n low run that never exceeds its width or falls outside a transfer. They also cover hs_fail_n, which may fall only at a timeout and may rise only after bus_start, and which otherwise holds. Other behaviour can only be shown by the bench's scenarios: the word order and the count (including the 32-word case), the strobe's place in its slot and the spacing between strobes, the grant that wins in the final waiting cycle, and stray start or grant pulses that are ignored.

// File: rtl/rt_xfer_handshake.sv
`timescale 1ns/1ps
module rt_xfer_handshake #(
  parameter int DW       = 16,
  parameter int WCW      = 5,
  parameter int SLOT_CYC = 16,
  parameter int STB_CYC  = 4,
  parameter int GNT_TMO  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer_start,
  input  logic [WCW-1:0] word_cnt,
  input  logic [DW-1:0]  cmd_word,
  input  logic [DW-1:0]  data_word,
  input  logic           bus_start,
  input  logic           grant_n,
  output logic           req_n,
  output logic           in_cmd,
  output logic           strobe_n,
  output logic           dat_ncmd,
  output logic [WCW:0]   word_idx,
  output logic [DW-1:0]  bus_data,
  output logic           hs_fail_n
);
  localparam int PW     = $clog2(SLOT_CYC);
  localparam int TW     = $clog2(GNT_TMO + 1);
  localparam int STB_LO = (SLOT_CYC - STB_CYC) / 2;
  localparam int STB_HI = STB_LO + STB_CYC;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER} st_t;

  st_t           state;
  logic [PW-1:0] phase;
  logic [TW-1:0] tmr;
  logic [WCW:0]  slot, last_q;
  logic [DW-1:0] cmd_q;
  logic          fail_q;

  wire phase_end = (phase == PW'(SLOT_CYC - 1));
  wire tmo_ev    = (state == S_WAIT) && grant_n && (tmr == TW'(GNT_TMO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      phase  <= '0;
      tmr    <= '0;
      slot   <= '0;
      last_q <= '0;
      cmd_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (xfer_start) begin
          state  <= S_WAIT;
          tmr    <= '0;
          slot   <= '0;
          phase  <= '0;
          cmd_q  <= cmd_word;
          last_q <= {(word_cnt == '0), word_cnt};
        end
        S_WAIT: begin
          if (!grant_n) begin
            state <= S_XFER;
            phase <= '0;
            slot  <= '0;
          end else if (tmo_ev) begin
            state <= S_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_XFER: begin
          if (phase_end) begin
            phase <= '0;
            if (slot == last_q) state <= S_IDLE;
            else                slot  <= slot + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fail_q <= 1'b0;
    else if (tmo_ev)    fail_q <= 1'b1;
    else if (bus_start) fail_q <= 1'b0;
  end

  assign req_n     = (state == S_IDLE);
  assign in_cmd    = (state != S_IDLE);
  assign strobe_n  = !((state == S_XFER) && (phase >= PW'(STB_LO)) && (phase < PW'(STB_HI)));
  assign dat_ncmd  = (state == S_XFER) && (slot != '0);
  assign word_idx  = slot;
  assign bus_data  = (slot == '0) ? cmd_q : data_word;
  assign hs_fail_n = !fail_q;
endmodule

// File: rtl/rt_xfer_handshake_chk.sv
`timescale 1ns/1ps
module rt_xfer_handshake_chk #(
  parameter int STB_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic bus_start,
  input logic req_n,
  input logic in_cmd,
  input logic strobe_n,
  input logic dat_ncmd,
  input logic hs_fail_n
);
  int lowrun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lowrun <= 0;
    else if (!strobe_n) lowrun <= lowrun + 1;
    else               lowrun <= 0;
  end

  // R7
  req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_n) |-> $fell(in_cmd));

  // R10
  req_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> $rose(in_cmd));

  // R6
  strobe_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_n |-> (in_cmd && !req_n));

  // R6
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lowrun <= STB_CYC);

  // R5
  dat_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ncmd |-> in_cmd);

  // R8
  fail_on_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hs_fail_n) |-> ($rose(req_n) && !in_cmd));

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_fail_n && !bus_start) |=> !hs_fail_n);

  // R9
  fail_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_fail_n) |-> $past(bus_start));
endmodule

bind rt_xfer_handshake rt_xfer_handshake_chk #(.STB_CYC(STB_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .req_n(req_n),
  .in_cmd(in_cmd), .strobe_n(strobe_n), .dat_ncmd(dat_ncmd), .hs_fail_n(hs_fail_n)
);

// File: tb/rt_xfer_handshake_bench.sv
`timescale 1ns/1ps
module rt_xfer_handshake_bench;
  localparam int SLOT = 16, STB = 4, TMO = 8;
  localparam int STB_LO = (SLOT - STB) / 2;

  logic clk = 0, rst_n = 0, xfer_start = 0, bus_start = 0, grant_n = 1;
  logic [4:0]  word_cnt = '0;
  logic [15:0] cmd_word = '0, data_word, bus_data;
  logic [5:0]  word_idx;
  logic req_n, in_cmd, strobe_n, dat_ncmd, hs_fail_n;

  int checks = 0, fails = 0, strobes = 0, lowlen = 0, cyc = 0, last_fall = -1;
  logic prev_stb = 1;
  logic [16:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;
  assign data_word = 16'hA500 | {10'd0, word_idx};

  rt_xfer_handshake #(.DW(16), .WCW(5), .SLOT_CYC(SLOT), .STB_CYC(STB), .GNT_TMO(TMO)) u_rt_xfer_handshake (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .word_cnt(word_cnt),
    .cmd_word(cmd_word), .data_word(data_word), .bus_start(bus_start),
    .grant_n(grant_n), .req_n(req_n), .in_cmd(in_cmd), .strobe_n(strobe_n),
    .dat_ncmd(dat_ncmd), .word_idx(word_idx), .bus_data(bus_data), .hs_fail_n(hs_fail_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected words at each strobe rising edge (R4, R5, R6)
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!in_cmd) last_fall = -1;
      if (!strobe_n && prev_stb) begin
        if (last_fall >= 0) chk("R6 strobe spacing", cyc - last_fall, SLOT);
        last_fall = cyc;
      end
      if (!strobe_n) lowlen++;
      if (strobe_n && !prev_stb) begin
        chk("R6 strobe width", lowlen, STB);
        lowlen = 0;
        strobes++;
        if (exp_q.size() == 0) chk("R4 unexpected word", {15'd0, dat_ncmd, bus_data}, 0);
        else begin
          logic [16:0] e;
          e = exp_q.pop_front();
          chk("R4/R5 word", {15'd0, dat_ncmd, bus_data}, {15'd0, e});
        end
      end
      prev_stb = strobe_n;
    end
  end

  task automatic run_xfer(input logic [15:0] cmd, input logic [4:0] wc, input int d, input bit poke);
    int nw, n, s0, first;
    nw = (wc == 0) ? 32 : wc;
    exp_q.push_back({1'b0, cmd});
    for (int k = 1; k <= nw; k++) exp_q.push_back({1'b1, 16'hA500 | 16'(k)});
    s0 = strobes;
    xfer_start = 1; word_cnt = wc; cmd_word = cmd;
    @(negedge clk); xfer_start = 0;
    chk("R2 request low", req_n, 0);
    chk("R10 in_cmd high", in_cmd, 1);
    repeat (d - 1) @(negedge clk);
    chk("R3 still waiting", req_n, 0);
    grant_n = 0;
    n = 0; first = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) grant_n = 1;
      if (poke && n == 20) xfer_start = 1;
      if (poke && n == 21) xfer_start = 0;
      if (!strobe_n && first == 0) first = n;
      if (n < (nw + 1) * SLOT && !in_cmd) begin
        chk("R10 in_cmd early drop", n, (nw + 1) * SLOT + 1);
        break;
      end
    end while (in_cmd && n < 5000);
    chk("R6 strobe offset", first, STB_LO + 1);
    chk("R4 duration", n, (nw + 1) * SLOT + 1);
    chk("R7 req released", req_n, 1);
    chk("R4 strobe count", strobes - s0, nw + 1);
    chk("R4 queue drained", exp_q.size(), 0);
  endtask

  task automatic run_timeout(input bit clash);
    int s0;
    s0 = strobes;
    xfer_start = 1; word_cnt = 5'd3; cmd_word = 16'h1234;
    @(negedge clk); xfer_start = 0;
    repeat (TMO - 1) @(negedge clk);
    chk("R8 waiting at last cycle", req_n, 0);
    if (clash) bus_start = 1;
    @(negedge clk); bus_start = 0;
    chk("R8 req released", req_n, 1);
    chk("R8 in_cmd low", in_cmd, 0);
    chk(clash ? "R9 timeout beats clear" : "R8 fail set", hs_fail_n, 0);
    chk("R8 no strobe", strobes - s0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 req_n", req_n, 1);
    chk("R1 in_cmd", in_cmd, 0);
    chk("R1 strobe_n", strobe_n, 1);
    chk("R1 dat_ncmd", dat_ncmd, 0);
    chk("R1 hs_fail_n", hs_fail_n, 1);

    // R3 grant while idle ignored
    grant_n = 0;
    repeat (5) @(negedge clk);
    chk("R3 idle grant req_n", req_n, 1);
    chk("R3 idle grant in_cmd", in_cmd, 0);
    chk("R3 idle grant strobe", strobes, 0);
    grant_n = 1;
    @(negedge clk);

    run_xfer(16'hC0DE, 5'd3, 2, 1'b0);
    run_xfer(16'h5A5A, 5'd1, 1, 1'b1);   // R2 stray start ignored
    run_xfer(16'h0F0F, 5'd0, 3, 1'b0);   // R4 count 0 means 32
    run_xfer(16'h8001, 5'd31, TMO, 1'b0); // R3 grant in final wait cycle
    chk("R9 no fail yet", hs_fail_n, 1);

    run_timeout(1'b0);
    run_xfer(16'h2222, 5'd2, 4, 1'b0);
    chk("R9 fail sticky", hs_fail_n, 0);
    bus_start = 1;
    @(negedge clk); bus_start = 0;
    chk("R9 fail cleared", hs_fail_n, 1);

    run_timeout(1'b1);
    @(negedge clk);
    chk("R9 fail held", hs_fail_n, 0);
    bus_start = 1;
    @(negedge clk); bus_start = 0;
    chk("R9 fail cleared again", hs_fail_n, 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule